// File: doc/BRIEF.md
# Nibble-Command Register Access Slave

This block lets a host reach a small 8-bit register file over a byte stream of commands. Each command byte has an opcode in bits 7:4 and a 4-bit payload in bits 3:0. The host builds an 8-bit register address one nibble at a time and stages a low data nibble. A separate command carries the high data nibble and commits the whole byte to the addressed register in the same step. A read command returns the addressed register as one byte on a reply stream.

The register file holds three registers. A fixed identification register reads 0xA6. A scratch register lets the host check the command path by writing a pattern and reading it back. A mode register drives a plain output, so that surrounding logic can follow the commanded operating mode.

Both byte streams use valid/ready handshakes. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. A reply transfers on an edge where `rsp_valid` and `rsp_ready` are both high. Once `rsp_valid` is high, the reply byte stays stable until it is accepted. While a reply is pending, the block refuses only read commands. All other commands are still accepted and take effect.

Top module: `nbc_reg_slave`

## Requirements
- R1: Command byte 0x0N sets bits 3:0 of the register address to N and leaves bits 7:4 unchanged.
- R2: Command byte 0x1N sets bits 7:4 of the register address to N and leaves bits 3:0 unchanged.
- R3: Command byte 0x2N stages N as the low data nibble and writes nothing. Command byte 0x3N writes {N, staged nibble} to the addressed register, and the new value is visible to a read accepted on any later cycle.
- R4: Any command byte 0x4N (N ignored) produces exactly one reply byte, equal to the contents of the addressed register at the cycle the read is accepted. The reply is valid in the cycle after acceptance.
- R5: Address 0x00 always reads 0xA6. Writes to it have no effect.
- R6: Address 0x0F is a read/write scratch register. For example, writing 0x55 reads back 0x55, and writing 0xAA reads back 0xAA.
- R7: Address 0x03 is the mode register. Its value is shown on `mode_q`, which changes only through a 0x3N write to address 0x03. The values used are 0x80 (analyzer mode), 0x11 (stop acquisition) and 0x02 (memory readout).
- R8: Any other address reads 0x00, and writes to it change no register.
- R9: Command bytes with opcode 0x5 through 0xF are accepted and change no state: not the address, not the staged nibble, not a register, and no reply.
- R10: The address and the staged nibble persist across commands, so repeated reads and writes need no reload.
- R11: A pending reply holds `rsp_valid` and `rsp_byte` until it is accepted. A read command is stalled (`cmd_ready` low) while a reply is pending. Non-read commands are always accepted.
- R12: Reset clears the address, the staged nibble, the scratch and mode registers, and any pending reply.
- R13: The bring-up sequence 00 10 40 0F 25 35 40 2A 3A 40 returns exactly 0xA6, 0x55, 0xAA, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte accepted when high with cmd_valid |
| cmd_byte | input | 8 | Command: opcode in bits 7:4, payload in bits 3:0 |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_ready | input | 1 | Downstream accepts the reply byte |
| rsp_byte | output | 8 | Reply byte (register contents) |
| mode_q | output | 8 | Current mode register value |

## Verification
The hardest situation to reach is a read that arrives while an earlier reply is still held, combined with a write to the same register during the hold. The bench holds `rsp_ready` low after a read. It then writes new data into the scratch register, which must be accepted while the held byte stays unchanged. It then presents a second read and checks that `cmd_ready` stays low over several cycles. Finally it releases the reply and checks that the old value drains first and the stalled read then returns the new value.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DATA_W = 2 * NIB_W;
  localparam int unsigned ADDR_W = 2 * NIB_W;

  typedef enum logic [2:0] {
    OP_ADDR_LO,
    OP_ADDR_HI,
    OP_DATA_LO,
    OP_DATA_HI_WR,
    OP_READ,
    OP_NONE
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [NIB_W-1:0] nib;
  } cmd_t;
endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
  import nbc_pkg::*;
(
  input  logic [DATA_W-1:0] byte_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o.nib = byte_i[NIB_W-1:0];
    unique case (byte_i[DATA_W-1:NIB_W])
      4'h0:    cmd_o.op = OP_ADDR_LO;
      4'h1:    cmd_o.op = OP_ADDR_HI;
      4'h2:    cmd_o.op = OP_DATA_LO;
      4'h3:    cmd_o.op = OP_DATA_HI_WR;
      4'h4:    cmd_o.op = OP_READ;
      default: cmd_o.op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/nbc_regfile.sv
module nbc_regfile
  import nbc_pkg::*;
#(
  parameter logic [ADDR_W-1:0]          ID_ADDR    = 8'h00,
  parameter logic [DATA_W-1:0]          ID_VALUE   = 8'hA6,
  parameter int unsigned                RW_COUNT   = 2,
  parameter logic [RW_COUNT*ADDR_W-1:0] RW_ADDRS   = {8'h0F, 8'h03},
  parameter int unsigned                MODE_INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  cmd_t              cmd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  stage_q;
  logic [DATA_W-1:0] regs_q [RW_COUNT];
  logic              wr_en;

  assign wr_en = fire_i && (cmd_i.op == OP_DATA_HI_WR);

  // Address and staged nibble persist until overwritten
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      stage_q <= '0;
    end else if (fire_i) begin
      case (cmd_i.op)
        OP_ADDR_LO: addr_q[NIB_W-1:0]      <= cmd_i.nib;
        OP_ADDR_HI: addr_q[ADDR_W-1:NIB_W] <= cmd_i.nib;
        OP_DATA_LO: stage_q                <= cmd_i.nib;
        default: ;
      endcase
    end
  end

  // One storage byte per writable address
  for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
    localparam logic [ADDR_W-1:0] MY_ADDR = RW_ADDRS[g*ADDR_W +: ADDR_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en && addr_q == MY_ADDR) begin
        regs_q[g] <= {cmd_i.nib, stage_q};
      end
    end
  end

  // Read mux: fixed identification first, then writable bytes, else zero
  always_comb begin
    rd_data_o = '0;
    if (addr_q == ID_ADDR) begin
      rd_data_o = ID_VALUE;
    end else begin
      for (int i = 0; i < RW_COUNT; i++) begin
        if (addr_q == RW_ADDRS[i*ADDR_W +: ADDR_W]) rd_data_o = regs_q[i];
      end
    end
  end

  assign mode_o = regs_q[MODE_INDEX];
endmodule

// File: rtl/nbc_reply.sv
module nbc_reply
  import nbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nbc_reg_slave.sv
module nbc_reg_slave
  import nbc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ID_ADDR      = 8'h00,
  parameter logic [DATA_W-1:0] ID_VALUE     = 8'hA6,
  parameter logic [ADDR_W-1:0] MODE_ADDR    = 8'h03,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_byte,
  output logic [DATA_W-1:0] mode_q
);
  localparam int unsigned RW_COUNT = 2;

  cmd_t              cmd;
  logic              fire;
  logic              is_read;
  logic [DATA_W-1:0] rd_data;

  nbc_decode u_decode (
    .byte_i (cmd_byte),
    .cmd_o  (cmd)
  );

  assign is_read   = (cmd.op == OP_READ);
  assign cmd_ready = !(rsp_valid && is_read);
  assign fire      = cmd_valid && cmd_ready;

  nbc_regfile #(
    .ID_ADDR    (ID_ADDR),
    .ID_VALUE   (ID_VALUE),
    .RW_COUNT   (RW_COUNT),
    .RW_ADDRS   ({SCRATCH_ADDR, MODE_ADDR}),
    .MODE_INDEX (0)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .cmd_i     (cmd),
    .rd_data_o (rd_data),
    .mode_o    (mode_q)
  );

  nbc_reply u_reply (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (fire && is_read),
    .data_i  (rd_data),
    .valid_o (rsp_valid),
    .ready_i (rsp_ready),
    .data_o  (rsp_byte)
  );
endmodule

// File: rtl/nbc_reg_slave_chk.sv
module nbc_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_byte,
  input logic [7:0] mode_q
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_reply_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  assert_read_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cmd_byte[7:4] == 4'h4) |-> !cmd_ready);

  assert_nonread_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte[7:4] != 4'h4) |-> cmd_ready);

  assert_read_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_byte[7:4] == 4'h4) |=> rsp_valid);

  assert_no_spurious_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !(acc && cmd_byte[7:4] == 4'h4)) |=> !rsp_valid);

  assert_mode_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && cmd_byte[7:4] == 4'h3) |=> $stable(mode_q));

  assert_reset_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && mode_q == 8'h00));
endmodule

bind nbc_reg_slave nbc_reg_slave_chk u_chk (.*);

// File: tb/nbc_reg_slave_bench.sv
`timescale 1ns/1ps
module nbc_reg_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_byte;
  logic [7:0] mode_q;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  nbc_reg_slave u_nbc_reg_slave (.*);

  // {cmd[20:13], expect_reply[12], expected[11:4], req[3:0]}
  localparam int NV = 43;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 1'b0, 8'h00, 4'd13}, // R13 bring-up
    {8'h10, 1'b0, 8'h00, 4'd13},
    {8'h40, 1'b1, 8'hA6, 4'd13},
    {8'h0F, 1'b0, 8'h00, 4'd13},
    {8'h25, 1'b0, 8'h00, 4'd13},
    {8'h35, 1'b0, 8'h00, 4'd13},
    {8'h40, 1'b1, 8'h55, 4'd13},
    {8'h2A, 1'b0, 8'h00, 4'd13},
    {8'h3A, 1'b0, 8'h00, 4'd13},
    {8'h40, 1'b1, 8'hAA, 4'd13},
    {8'h41, 1'b1, 8'hAA, 4'd6},  // R6 read opcode ignores nibble
    {8'h03, 1'b0, 8'h00, 4'd1},  // R1 low address nibble
    {8'h20, 1'b0, 8'h00, 4'd7},  // R7 analyzer mode 0x80
    {8'h38, 1'b0, 8'h00, 4'd7},
    {8'h40, 1'b1, 8'h80, 4'd7},
    {8'h21, 1'b0, 8'h00, 4'd7},  // R7 stop 0x11
    {8'h31, 1'b0, 8'h00, 4'd7},
    {8'h40, 1'b1, 8'h11, 4'd7},
    {8'h22, 1'b0, 8'h00, 4'd7},  // R7 readout 0x02
    {8'h40, 1'b1, 8'h11, 4'd3},  // R3 staging alone writes nothing
    {8'h30, 1'b0, 8'h00, 4'd7},
    {8'h40, 1'b1, 8'h02, 4'd7},
    {8'h3C, 1'b0, 8'h00, 4'd10}, // R10 staged nibble reused
    {8'h40, 1'b1, 8'hC2, 4'd10},
    {8'h5F, 1'b0, 8'h00, 4'd9},  // R9 ignored opcodes
    {8'h7A, 1'b0, 8'h00, 4'd9},
    {8'hFF, 1'b0, 8'h00, 4'd9},
    {8'h40, 1'b1, 8'hC2, 4'd9},
    {8'h3E, 1'b0, 8'h00, 4'd9},  // staged nibble still 2
    {8'h40, 1'b1, 8'hE2, 4'd9},
    {8'h11, 1'b0, 8'h00, 4'd2},  // R2 high nibble -> addr 0x13
    {8'h40, 1'b1, 8'h00, 4'd8},  // R8 unmapped reads zero
    {8'h25, 1'b0, 8'h00, 4'd8},
    {8'h35, 1'b0, 8'h00, 4'd8},
    {8'h40, 1'b1, 8'h00, 4'd8},
    {8'h10, 1'b0, 8'h00, 4'd2},  // R2 back to 0x03
    {8'h40, 1'b1, 8'hE2, 4'd2},
    {8'h0F, 1'b0, 8'h00, 4'd8},  // scratch untouched by 0x13 write
    {8'h40, 1'b1, 8'hAA, 4'd8},
    {8'h00, 1'b0, 8'h00, 4'd5},  // R5 id is read-only
    {8'h2F, 1'b0, 8'h00, 4'd5},
    {8'h3F, 1'b0, 8'h00, 4'd5},
    {8'h40, 1'b1, 8'hA6, 4'd5}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic get_reply(output logic [7:0] b);
    @(negedge clk);
    rsp_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    b = rsp_byte;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    do_reset();
    // R12 reset state
    @(negedge clk);
    check({7'd0, rsp_valid}, 8'h00, "R12 rsp_valid after reset");
    check(mode_q, 8'h00, "R12 mode after reset");
    check({7'd0, cmd_ready}, 8'h01, "R12 cmd_ready after reset");
    send(8'h40);
    get_reply(r);
    check(r, 8'hA6, "R12 address cleared to id");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20:13]);
      if (VEC[i][12]) begin
        get_reply(r);
        check(r, VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
      end
    end
    @(negedge clk);
    check(mode_q, 8'hE2, "R7 mode_q output");
    check({7'd0, rsp_valid}, 8'h00, "R4 single reply only");

    // R12 reset mid-run clears mode, scratch, address, staged nibble
    do_reset();
    @(negedge clk);
    check(mode_q, 8'h00, "R12 mode cleared");
    send(8'h0F);
    send(8'h40);
    get_reply(r);
    check(r, 8'h00, "R12 scratch cleared");
    send(8'h3B);
    send(8'h40);
    get_reply(r);
    check(r, 8'hB0, "R12 staged nibble cleared");

    // R11 back-pressure
    send(8'h40);
    @(negedge clk);
    check({7'd0, rsp_valid}, 8'h01, "R11 reply pending");
    send(8'h2D);
    send(8'h3D);
    @(negedge clk);
    check(rsp_byte, 8'hB0, "R11 held byte stable across write");
    cmd_valid = 1'b1;
    cmd_byte  = 8'h40;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({7'd0, cmd_ready}, 8'h00, "R11 read stalled");
      check({7'd0, rsp_valid}, 8'h01, "R11 valid held");
    end
    get_reply(r);
    check(r, 8'hB0, "R11 old reply drains first");
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    get_reply(r);
    check(r, 8'hDD, "R11 stalled read returns new data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule